// File: doc/BRIEF.md
# Flash Status and Write-Protection Controller

This block keeps the two status bytes of a serial flash device and decides whether each write-type request may go ahead. A command decoder upstream presents one decoded event per cycle on `cmd_valid`/`cmd_op`: latch set, latch clear, a one-byte or two-byte status write, byte program, word program (auto-incrementing), range erase or full-array erase. Program and erase requests carry an inclusive byte range. The block answers each status write, program or erase request with a one-cycle `req_grant` or `req_deny` pulse. It also sets the busy bit until the array sequencer returns `op_done`. The array, the serial shifter and the operation timing live elsewhere.

Protection has three layers. A two-bit level field guards an upper fraction of a 256 KB array. Two independent sector locks guard the lowest and highest 4 KB sectors. A lock-down bit, enabled only while the write-protect pin `wp_n` is low, freezes all of these bits. The control sequencer has four states. ST_IDLE accepts every command. ST_BUSY waits for a granted single operation to finish. ST_WORD_BUSY waits for one word of a word-program run to finish. ST_WORD_WAIT holds the run open between words. Its transitions are:
- start (ST_IDLE to ST_BUSY on a granted byte program or erase);
- finish (ST_BUSY to ST_IDLE on `op_done`);
- word start (ST_IDLE to ST_WORD_BUSY on a granted word program);
- word done (ST_WORD_BUSY to ST_WORD_WAIT on `op_done`);
- word next (ST_WORD_WAIT to ST_WORD_BUSY on a granted continuation);
- word end (ST_WORD_WAIT to ST_IDLE on latch clear or a denied continuation).

Top module: `flash_status_guard`

## Requirements
- R1: After reset, status byte 0 reads 0x0C (level field 11), status byte 1 reads 0x00, and neither pulse is active.
- R2: In ST_IDLE, op 1 sets the write-enable latch (status byte 0 bit 1) and op 2 clears it. Neither produces a grant or deny pulse.
- R3: A status write (op 3 or 4) is granted only when the latch is 1 and either `wp_n` is 1 or the lock-down bit (byte 0 bit 7) is 0. A granted write clears the latch. A denied write changes no bit.
- R4: A granted status write loads byte 0 bit 7 from `wr_lock` and bits 3:2 from `wr_bp`. Op 4 also loads byte 1 bit 2 from `wr_top_lock` and bit 3 from `wr_bot_lock`. Op 3 leaves byte 1 unchanged.
- R5: Level 01 protects addresses 0x30000 and up, level 10 protects 0x20000 and up, level 11 protects everything, and level 00 protects nothing. A request whose range reaches a protected address is denied.
- R6: With byte 1 bit 2 set, a request touching 0x3F000..0x3FFFF is denied. With byte 1 bit 3 set, a request touching 0x00000..0x00FFF is denied.
- R7: Full-array erase (op 8) is granted only when the level field is 00, both sector locks are 0 and the latch is 1.
- R8: Byte program (op 5) and range erase (op 7) need the latch. A granted request sets busy (byte 0 bit 0) until `op_done`, after which busy and the latch both read 0.
- R9: While busy is 1, every command is ignored: no pulse is produced and the status bytes do not change.
- R10: A granted word program (op 6) on address A covers A with bit 0 cleared and A with bit 0 set, and sets byte 0 bit 6 and busy. `op_done` clears busy but keeps bit 6 and the latch. Each further op 6 covers the next word, ignoring its address inputs. Op 2 ends the run and clears bit 6 and the latch. All other commands are ignored between words.
- R11: A continuation whose word is protected or lies past 0x3FFFF is denied. It ends the run and clears bit 6 and the latch.
- R12: Each status write, program or erase request seen in ST_IDLE (or a continuation in ST_WORD_WAIT) produces exactly one grant or deny pulse, in the cycle after the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 4 | Command code (0 none, 1 latch set, 2 latch clear, 3 one-byte status write, 4 two-byte status write, 5 byte program, 6 word program, 7 range erase, 8 full erase) |
| cmd_lo | input | ADDR_W | Lowest byte address of the target range |
| cmd_hi | input | ADDR_W | Highest byte address of the target range |
| wr_lock | input | 1 | Status write value for the lock-down bit |
| wr_bp | input | 2 | Status write value for the level field |
| wr_top_lock | input | 1 | Status write value for the top sector lock |
| wr_bot_lock | input | 1 | Status write value for the bottom sector lock |
| wp_n | input | 1 | Write-protect pin level |
| op_done | input | 1 | The array sequencer finished the running operation |
| status0 | output | 8 | Status byte 0 |
| status1 | output | 8 | Status byte 1 |
| req_grant | output | 1 | One-cycle pulse: request accepted |
| req_deny | output | 1 | One-cycle pulse: request refused |

## Verification
Single-byte programs at 0x1FFFF, 0x20000, 0x2FFFF and 0x30000 step across each level boundary. A grant on one side and a deny on the other shows that each boundary sits at the exact address. Programs and erases near 0x00010 and 0x3F800, with sector locks set and cleared, separate the sector checks from the level checks. Status writes at each combination of `wp_n` and the lock-down bit show whether the pin really gates the lock. A word-program run climbing into the top word and past it, and another climbing into a protected quarter, tell the overflow stop apart from the protection stop.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_WREN  = 4'd1,
        OP_WRDI  = 4'd2,
        OP_WRSR1 = 4'd3,
        OP_WRSR2 = 4'd4,
        OP_BYTE  = 4'd5,
        OP_WORD  = 4'd6,
        OP_ERASE = 4'd7,
        OP_CHIP  = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_BUSY      = 2'd1,
        ST_WORD_BUSY = 2'd2,
        ST_WORD_WAIT = 2'd3
    } state_e;

endpackage

// File: rtl/fsg_protect_check.sv
module fsg_protect_check #(
    parameter int ADDR_W = 18,
    parameter int SECT_W = 12
) (
    input  logic [1:0]               level,
    input  logic                     top_lock,
    input  logic                     bot_lock,
    input  logic [ADDR_W-SECT_W-1:0] lo_sect,
    input  logic [ADDR_W-1:0]        hi,
    output logic                     blocked
);
    localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W - 1);

    logic [ADDR_W-1:0] prot_base;
    logic              level_hit;
    logic              top_hit;
    logic              bot_hit;

    always_comb begin
        unique case (level)
            2'b01:   prot_base = QUARTER_BASE;
            2'b10:   prot_base = HALF_BASE;
            default: prot_base = '0;
        endcase
        level_hit = (level != 2'b00) && (hi >= prot_base);
        top_hit   = top_lock && (&hi[ADDR_W-1:SECT_W]);
        bot_hit   = bot_lock && (lo_sect == '0);
        blocked   = level_hit || top_hit || bot_hit;
    end

    // R5: the highest level guards every address
    always_comb begin
        if (!$isunknown(level) && level == 2'b11) begin
            a_r5_full_level_blocks: assert (blocked)
                else $error("R5: level 11 did not block");
        end
    end

endmodule

// File: rtl/fsg_status_bits.sv
module fsg_status_bits (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_two,
    input  logic       lock_in,
    input  logic [1:0] level_in,
    input  logic       top_in,
    input  logic       bot_in,
    input  logic       wp_n,
    output logic       unlocked,
    output logic       lock_q,
    output logic [1:0] level_q,
    output logic       top_q,
    output logic       bot_q
);
    assign unlocked = wp_n || !lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            level_q <= 2'b11;
            top_q   <= 1'b0;
            bot_q   <= 1'b0;
        end else if (wr_en) begin
            lock_q  <= lock_in;
            level_q <= level_in;
            if (wr_two) begin
                top_q <= top_in;
                bot_q <= bot_in;
            end
        end
    end

    // R3: with the pin low and lock-down set, every guarded bit holds
    a_r3_frozen_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !wp_n) |=> $stable({lock_q, level_q, top_q, bot_q}))
        else $error("R3: guarded bits changed while locked");

    // R4: a one-byte write leaves the sector locks alone
    a_r4_short_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_two) |=> $stable({top_q, bot_q}))
        else $error("R4: one-byte write touched byte 1");

endmodule

// File: rtl/fsg_sequencer.sv
module fsg_sequencer
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_lo,
    input  logic [ADDR_W-1:0] cmd_hi,
    input  logic              op_done,
    input  logic              blocked,
    input  logic              sr_unlocked,
    output logic [ADDR_W-1:0] chk_lo,
    output logic [ADDR_W-1:0] chk_hi,
    output logic              sr_we,
    output logic              sr_two,
    output logic              wel_q,
    output logic              busy,
    output logic              aai,
    output logic              grant_q,
    output logic              deny_q
);
    localparam int PTR_W = ADDR_W + 1;

    op_e              op;
    state_e           state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             wel_set, wel_clr;
    logic             grant_d, deny_d;
    logic             mem_ok;

    assign op     = op_e'(cmd_op);
    assign sr_two = (op == OP_WRSR2);
    assign mem_ok = wel_q && !blocked;
    assign busy   = (state_q == ST_BUSY) || (state_q == ST_WORD_BUSY);
    assign aai    = (state_q == ST_WORD_BUSY) || (state_q == ST_WORD_WAIT);

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        wel_set = 1'b0;
        wel_clr = 1'b0;
        grant_d = 1'b0;
        deny_d  = 1'b0;
        sr_we   = 1'b0;
        chk_lo  = cmd_lo;
        chk_hi  = cmd_hi;
        unique case (state_q)
            ST_IDLE: begin
                if (op == OP_CHIP) begin
                    chk_lo = '0;
                    chk_hi = '1;
                end else if (op == OP_WORD) begin
                    chk_lo = {cmd_lo[ADDR_W-1:1], 1'b0};
                    chk_hi = {cmd_lo[ADDR_W-1:1], 1'b1};
                end
                if (cmd_valid) begin
                    unique case (op)
                        OP_WREN: wel_set = 1'b1;
                        OP_WRDI: wel_clr = 1'b1;
                        OP_WRSR1, OP_WRSR2: begin
                            if (wel_q && sr_unlocked) begin
                                sr_we   = 1'b1;
                                wel_clr = 1'b1;
                                grant_d = 1'b1;
                            end else begin
                                deny_d = 1'b1;
                            end
                        end
                        OP_BYTE, OP_ERASE, OP_CHIP: begin
                            if (mem_ok) begin
                                grant_d = 1'b1;
                                state_d = ST_BUSY;
                            end else begin
                                deny_d = 1'b1;
                            end
                        end
                        OP_WORD: begin
                            if (mem_ok) begin
                                grant_d = 1'b1;
                                state_d = ST_WORD_BUSY;
                                ptr_d   = {1'b0, chk_lo} + PTR_W'(2);
                            end else begin
                                deny_d = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_BUSY: begin
                if (op_done) begin
                    state_d = ST_IDLE;
                    wel_clr = 1'b1;
                end
            end
            ST_WORD_BUSY: begin
                if (op_done) state_d = ST_WORD_WAIT;
            end
            ST_WORD_WAIT: begin
                chk_lo = ptr_q[ADDR_W-1:0];
                chk_hi = ptr_q[ADDR_W-1:0] | ADDR_W'(1);
                if (cmd_valid && op == OP_WORD) begin
                    if (!ptr_q[ADDR_W] && mem_ok) begin
                        grant_d = 1'b1;
                        state_d = ST_WORD_BUSY;
                        ptr_d   = ptr_q + PTR_W'(2);
                    end else begin
                        deny_d  = 1'b1;
                        state_d = ST_IDLE;
                        wel_clr = 1'b1;
                    end
                end else if (cmd_valid && op == OP_WRDI) begin
                    state_d = ST_IDLE;
                    wel_clr = 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q   <= 1'b0;
            ptr_q   <= '0;
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            if (wel_clr)      wel_q <= 1'b0;
            else if (wel_set) wel_q <= 1'b1;
            ptr_q   <= ptr_d;
            grant_q <= grant_d;
            deny_q  <= deny_d;
        end
    end

    // R8: no grant without the latch having been set
    a_r8_grant_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        grant_q |-> $past(wel_q))
        else $error("R8: grant without latch");

    // R8: completion of a single operation drops busy and the latch
    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && op_done) |=> (!wel_q && !busy))
        else $error("R8: completion did not clear");

    // R9: no response while an operation runs
    a_r9_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!grant_q && !deny_q))
        else $error("R9: pulse while busy");

    // R10: a finished word keeps the run and the latch
    a_r10_word_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WORD_BUSY && op_done) |=> (wel_q && aai && !busy))
        else $error("R10: word completion lost run state");

    // R12: the two pulses never coincide
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({grant_q, deny_q}) <= 1)
        else $error("R12: both pulses");

endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
    parameter int ADDR_W = 18,
    parameter int SECT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_lo,
    input  logic [ADDR_W-1:0] cmd_hi,
    input  logic              wr_lock,
    input  logic [1:0]        wr_bp,
    input  logic              wr_top_lock,
    input  logic              wr_bot_lock,
    input  logic              wp_n,
    input  logic              op_done,
    output logic [7:0]        status0,
    output logic [7:0]        status1,
    output logic              req_grant,
    output logic              req_deny
);
    logic [ADDR_W-1:0] chk_lo, chk_hi;
    logic              blocked, sr_unlocked, sr_we, sr_two;
    logic              wel, busy, aai;
    logic              lock_q, top_q, bot_q;
    logic [1:0]        level_q;

    fsg_sequencer #(.ADDR_W(ADDR_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_lo      (cmd_lo),
        .cmd_hi      (cmd_hi),
        .op_done     (op_done),
        .blocked     (blocked),
        .sr_unlocked (sr_unlocked),
        .chk_lo      (chk_lo),
        .chk_hi      (chk_hi),
        .sr_we       (sr_we),
        .sr_two      (sr_two),
        .wel_q       (wel),
        .busy        (busy),
        .aai         (aai),
        .grant_q     (req_grant),
        .deny_q      (req_deny)
    );

    fsg_status_bits i_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sr_we),
        .wr_two   (sr_two),
        .lock_in  (wr_lock),
        .level_in (wr_bp),
        .top_in   (wr_top_lock),
        .bot_in   (wr_bot_lock),
        .wp_n     (wp_n),
        .unlocked (sr_unlocked),
        .lock_q   (lock_q),
        .level_q  (level_q),
        .top_q    (top_q),
        .bot_q    (bot_q)
    );

    fsg_protect_check #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_prot (
        .level    (level_q),
        .top_lock (top_q),
        .bot_lock (bot_q),
        .lo_sect  (chk_lo[ADDR_W-1:SECT_W]),
        .hi       (chk_hi),
        .blocked  (blocked)
    );

    assign status0 = {lock_q, aai, 2'b00, level_q, wel, busy};
    assign status1 = {4'b0000, bot_q, top_q, 2'b00};

endmodule

// File: tb/test_flash_status_guard.sv
module test_flash_status_guard;

    typedef struct {
        logic [7:0] s0;
        logic [7:0] s1;
        logic       g;
        logic       d;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [17:0] cmd_lo = '0, cmd_hi = '0;
    logic        wr_lock = 1'b0, wr_top_lock = 1'b0, wr_bot_lock = 1'b0;
    logic [1:0]  wr_bp = 2'b00;
    logic        wp_n = 1'b1;
    logic        op_done = 1'b0;
    logic [7:0]  status0, status1;
    logic        req_grant, req_deny;

    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    exp_t sbq[$];

    always #5 clk = ~clk;

    flash_status_guard i_flash_status_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .wr_lock(wr_lock), .wr_bp(wr_bp),
        .wr_top_lock(wr_top_lock), .wr_bot_lock(wr_bot_lock), .wp_n(wp_n),
        .op_done(op_done), .status0(status0), .status1(status1),
        .req_grant(req_grant), .req_deny(req_deny)
    );

    // sw packs {lock, bp1, bp0, bottom lock, top lock}
    task automatic step(input logic [3:0] op, input logic [17:0] lo, input logic [17:0] hi,
                        input logic [4:0] sw, input logic wp, input logic done,
                        input logic [7:0] e0, input logic [7:0] e1,
                        input logic eg, input logic ed, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid   = (op != 4'd0);
        cmd_op      = op;
        cmd_lo      = lo;
        cmd_hi      = hi;
        wr_lock     = sw[4];
        wr_bp       = sw[3:2];
        wr_bot_lock = sw[1];
        wr_top_lock = sw[0];
        wp_n        = wp;
        op_done     = done;
        @(posedge clk);
        #1;
        e.s0 = e0; e.s1 = e1; e.g = eg; e.d = ed; e.tag = tag;
        sbq.push_back(e);
        cmd_valid = 1'b0;
        cmd_op    = 4'd0;
        op_done   = 1'b0;
    endtask

    // monitor: compares each result one edge after its request
    always @(negedge clk) begin : monitor
        exp_t e;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            checks++;
            if (status0 !== e.s0 || status1 !== e.s1 || req_grant !== e.g || req_deny !== e.d) begin
                fails++;
                $display("FAIL %s: got s0=%02h s1=%02h g=%0b d=%0b, expected s0=%02h s1=%02h g=%0b d=%0b",
                         e.tag, status0, status1, req_grant, req_deny, e.s0, e.s1, e.g, e.d);
            end
        end
    end

    initial begin : watchdog
        #1_000_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R12 watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 0, 5'b00000, 1, 0, 8'h0C, 8'h00, 0, 0, "R1 reset");
        // R8 no latch, R2 latch set/clear
        step(5, 18'h00100, 18'h00100, 0, 1, 0, 8'h0C, 8'h00, 0, 1, "R8 program without latch");
        step(1, 0, 0, 0, 1, 0, 8'h0E, 8'h00, 0, 0, "R2 latch set");
        step(2, 0, 0, 0, 1, 0, 8'h0C, 8'h00, 0, 0, "R2 latch clear");
        step(3, 0, 0, 0, 1, 0, 8'h0C, 8'h00, 0, 1, "R3 status write without latch");
        step(1, 0, 0, 0, 1, 0, 8'h0E, 8'h00, 0, 0, "R2 latch set");
        step(3, 0, 0, 5'b00000, 1, 0, 8'h00, 8'h00, 1, 0, "R3 R4 one-byte write");
        step(1, 0, 0, 0, 1, 0, 8'h02, 8'h00, 0, 0, "R2 latch set");
        step(4, 0, 0, 5'b10111, 1, 0, 8'h84, 8'h0C, 1, 0, "R4 two-byte write");
        step(1, 0, 0, 0, 1, 0, 8'h86, 8'h0C, 0, 0, "R2 latch set");
        step(3, 0, 0, 5'b00000, 0, 0, 8'h86, 8'h0C, 0, 1, "R3 locked with pin low");
        step(3, 0, 0, 5'b00000, 1, 0, 8'h00, 8'h0C, 1, 0, "R3 R4 pin high overrides lock");
        // R6 sector locks
        step(1, 0, 0, 0, 1, 0, 8'h02, 8'h0C, 0, 0, "R2 latch set");
        step(5, 18'h3F800, 18'h3F800, 0, 1, 0, 8'h02, 8'h0C, 0, 1, "R6 top sector");
        step(5, 18'h00010, 18'h00010, 0, 1, 0, 8'h02, 8'h0C, 0, 1, "R6 bottom sector");
        step(7, 18'h20000, 18'h2FFFF, 0, 1, 0, 8'h03, 8'h0C, 1, 0, "R8 erase granted");
        step(1, 0, 0, 0, 1, 0, 8'h03, 8'h0C, 0, 0, "R9 latch set ignored");
        step(4, 0, 0, 5'b00000, 1, 0, 8'h03, 8'h0C, 0, 0, "R9 status write ignored");
        step(0, 0, 0, 0, 1, 1, 8'h00, 8'h0C, 0, 0, "R8 completion");
        // R5 levels
        step(1, 0, 0, 0, 1, 0, 8'h02, 8'h0C, 0, 0, "R2 latch set");
        step(4, 0, 0, 5'b00100, 1, 0, 8'h04, 8'h00, 1, 0, "R4 level 01");
        step(1, 0, 0, 0, 1, 0, 8'h06, 8'h00, 0, 0, "R2 latch set");
        step(5, 18'h30000, 18'h30000, 0, 1, 0, 8'h06, 8'h00, 0, 1, "R5 quarter edge");
        step(5, 18'h2FFFF, 18'h2FFFF, 0, 1, 0, 8'h07, 8'h00, 1, 0, "R5 below quarter");
        step(0, 0, 0, 0, 1, 1, 8'h04, 8'h00, 0, 0, "R8 completion");
        step(1, 0, 0, 0, 1, 0, 8'h06, 8'h00, 0, 0, "R2 latch set");
        step(8, 0, 0, 0, 1, 0, 8'h06, 8'h00, 0, 1, "R7 full erase with level");
        step(3, 0, 0, 5'b01000, 1, 0, 8'h08, 8'h00, 1, 0, "R4 level 10");
        step(1, 0, 0, 0, 1, 0, 8'h0A, 8'h00, 0, 0, "R2 latch set");
        step(5, 18'h20000, 18'h20000, 0, 1, 0, 8'h0A, 8'h00, 0, 1, "R5 half edge");
        step(5, 18'h1FFFF, 18'h1FFFF, 0, 1, 0, 8'h0B, 8'h00, 1, 0, "R5 below half");
        step(0, 0, 0, 0, 1, 1, 8'h08, 8'h00, 0, 0, "R8 completion");
        // R7 full erase
        step(1, 0, 0, 0, 1, 0, 8'h0A, 8'h00, 0, 0, "R2 latch set");
        step(3, 0, 0, 5'b00000, 1, 0, 8'h00, 8'h00, 1, 0, "R4 level 00");
        step(1, 0, 0, 0, 1, 0, 8'h02, 8'h00, 0, 0, "R2 latch set");
        step(8, 0, 0, 0, 1, 0, 8'h03, 8'h00, 1, 0, "R7 full erase granted");
        step(0, 0, 0, 0, 1, 1, 8'h00, 8'h00, 0, 0, "R8 completion");
        step(1, 0, 0, 0, 1, 0, 8'h02, 8'h00, 0, 0, "R2 latch set");
        step(4, 0, 0, 5'b00001, 1, 0, 8'h00, 8'h04, 1, 0, "R4 top lock");
        step(1, 0, 0, 0, 1, 0, 8'h02, 8'h04, 0, 0, "R2 latch set");
        step(8, 0, 0, 0, 1, 0, 8'h02, 8'h04, 0, 1, "R7 full erase with sector lock");
        step(4, 0, 0, 5'b00000, 1, 0, 8'h00, 8'h00, 1, 0, "R4 clear locks");
        // R10 R11 word run up to the top
        step(1, 0, 0, 0, 1, 0, 8'h02, 8'h00, 0, 0, "R2 latch set");
        step(6, 18'h3FFFB, 18'h3FFFB, 0, 1, 0, 8'h43, 8'h00, 1, 0, "R10 word start");
        step(0, 0, 0, 0, 1, 1, 8'h42, 8'h00, 0, 0, "R10 word done");
        step(6, 0, 0, 0, 1, 0, 8'h43, 8'h00, 1, 0, "R10 next word");
        step(0, 0, 0, 0, 1, 1, 8'h42, 8'h00, 0, 0, "R10 word done");
        step(1, 0, 0, 0, 1, 0, 8'h42, 8'h00, 0, 0, "R10 latch set ignored between words");
        step(6, 0, 0, 0, 1, 0, 8'h43, 8'h00, 1, 0, "R10 last word");
        step(0, 0, 0, 0, 1, 1, 8'h42, 8'h00, 0, 0, "R10 word done");
        step(6, 0, 0, 0, 1, 0, 8'h00, 8'h00, 0, 1, "R11 past top");
        // R11 run into protected quarter
        step(1, 0, 0, 0, 1, 0, 8'h02, 8'h00, 0, 0, "R2 latch set");
        step(3, 0, 0, 5'b00100, 1, 0, 8'h04, 8'h00, 1, 0, "R4 level 01");
        step(1, 0, 0, 0, 1, 0, 8'h06, 8'h00, 0, 0, "R2 latch set");
        step(6, 18'h2FFFC, 18'h2FFFC, 0, 1, 0, 8'h47, 8'h00, 1, 0, "R10 word start");
        step(0, 0, 0, 0, 1, 1, 8'h46, 8'h00, 0, 0, "R10 word done");
        step(6, 0, 0, 0, 1, 0, 8'h47, 8'h00, 1, 0, "R10 next word");
        step(0, 0, 0, 0, 1, 1, 8'h46, 8'h00, 0, 0, "R10 word done");
        step(6, 0, 0, 0, 1, 0, 8'h04, 8'h00, 0, 1, "R11 protected word");
        // R10 latch clear ends run
        step(1, 0, 0, 0, 1, 0, 8'h06, 8'h00, 0, 0, "R2 latch set");
        step(6, 18'h00100, 18'h00100, 0, 1, 0, 8'h47, 8'h00, 1, 0, "R10 word start");
        step(0, 0, 0, 0, 1, 1, 8'h46, 8'h00, 0, 0, "R10 word done");
        step(3, 0, 0, 5'b00000, 1, 0, 8'h46, 8'h00, 0, 0, "R10 status write ignored between words");
        step(2, 0, 0, 0, 1, 0, 8'h04, 8'h00, 0, 0, "R10 latch clear ends run");
        step(0, 0, 0, 0, 1, 0, 8'h04, 8'h00, 0, 0, "R12 no stray pulse");
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule